// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, on the receive side of an Ethernet MAC, whether a frame with a given 48-bit destination address should be kept. For each address presented with a one-cycle strobe it computes the 32-bit Ethernet CRC over the six address bytes. The high bits of that CRC pick one slot of a group hash table. The block returns a registered accept or reject decision a fixed two cycles later.

The block holds two tables of equal size, an individual table and a group table, in a bank of 32-bit registers. Software reads and writes the bank through a simple word port. The individual table is storage only: the exact compare of unicast addresses happens elsewhere, and its result enters this block on a match input. Two shift parameters set the table geometry, one for the number of slots and one for the used register width. The default gives 64 slots over four 16-bit-wide words. The alternative gives 256 slots over eight full 32-bit words. The register count and the window base address both follow from the two shift parameters.

Three mode inputs shape the decision: promiscuous, all-multicast and hash-enable.

Top module: `mc_hash_filter`

## Requirements
- R1: The CRC starts at all ones and uses polynomial 0x04C11DB7. Bytes are taken first byte first, where the first byte is da[47:40], and the bits within each byte are taken LSB first. No final inversion is applied. The slot equals (SLOTS−1) minus the top log2(SLOTS) CRC bits.
- R2: Slot s lives in group word s >> log2(W), where W is the used width. Within that word it is bit (W−1) − (s mod W), so the lowest slot of a word sits in its most significant used bit.
- R3: The bank is a window of word-aligned byte addresses starting at BASE. BASE is 0x30 for 64 slots and 0x80 for 256 slots. The individual words come first, then an equal number of group words. An unaligned address or an address outside the window reads 0, and a write to it changes nothing.
- R4: Reset clears every table word to zero and clears dec_valid.
- R5: With mode_promisc set, every address is accepted.
- R6: With mode_allmc set, every multicast address is accepted.
- R7: When neither promiscuous nor all-multicast applies, a multicast address is accepted only if mode_hash_en is 1 and its group table bit is 1.
- R8: When not promiscuous, a unicast address is accepted exactly when uc_match is 1, regardless of the hash table.
- R9: dec_valid is high for one cycle, two clock edges after the edge that samples da_valid. The decision uses the inputs sampled with the strobe.
- R10: In the 64-slot configuration, bits 31:16 of every table word ignore writes and read as zero.
- R11: An address is multicast exactly when da[40], bit 0 of the first byte, is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| da_valid | input | 1 | Strobe: da and the mode inputs are valid |
| da | input | 48 | Destination address, first byte in [47:40] |
| uc_match | input | 1 | Result of the external exact unicast compare |
| mode_promisc | input | 1 | Accept every frame |
| mode_allmc | input | 1 | Accept every multicast frame |
| mode_hash_en | input | 1 | Enable group hash matching |
| cfg_we | input | 1 | Table word write enable |
| cfg_addr | input | ADDR_W | Byte address of the table word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational from cfg_addr |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |

## Verification
The hardest case to reach is a multicast address that hits one particular slot while that slot's bit alone decides the outcome. Reaching it needs a table in which exactly that bit, or every bit except it, is set. The bench computes the slot of a chosen address with its own CRC and mapping functions. It then writes a group table holding only that bit, and afterwards its complement, so that a wrong word index or a wrong bit order flips the answer. Random tables and addresses, with the mode bits drawn sparsely, cover the remaining mixes against a bench-side model of the bank.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam int          DA_BYTES = 6;

    typedef struct packed {
        logic promisc;
        logic allmc;
        logic hash_en;
    } mode_t;

    typedef struct packed {
        logic  mc;
        logic  uc_hit;
        mode_t mode;
    } req_t;

    // Advance the CRC by one byte, least significant bit first.
    function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[31] ^ b[i];
            c  = {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return c;
    endfunction

    // CRC of the six address bytes, first byte taken from the top of da.
    function automatic logic [31:0] da_crc(input logic [47:0] da);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < DA_BYTES; k++) begin
            c = crc_byte(c, da[47 - 8*k -: 8]);
        end
        return c;
    endfunction

    // Byte offset of the table window, chosen by table size.
    function automatic int hash_base(input int slot_shift);
        return (slot_shift > 6) ? 'h80 : 'h30;
    endfunction

endpackage

// File: rtl/mhf_crc_slot.sv
module mhf_crc_slot
    import mhf_pkg::*;
#(
    parameter int SLOT_SHIFT = 6
) (
    input  logic [47:0]           da,
    output logic [SLOT_SHIFT-1:0] slot
);
    logic [31:0] crc;

    always_comb begin
        crc  = da_crc(da);
        // (SLOTS-1) minus the top bits is the bitwise complement of them.
        slot = ~crc[31 -: SLOT_SHIFT];
    end
endmodule

// File: rtl/mhf_table_bank.sv
module mhf_table_bank
    import mhf_pkg::*;
#(
    parameter int SLOT_SHIFT  = 6,
    parameter int WIDTH_SHIFT = 4,
    parameter int ADDR_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic [SLOT_SHIFT-1:0] lk_slot,
    output logic                  lk_hit
);
    localparam int W     = 1 << WIDTH_SHIFT;
    localparam int RIDXW = SLOT_SHIFT - WIDTH_SHIFT;
    localparam int REGS  = 1 << RIDXW;
    localparam int IDXW  = RIDXW + 1;
    localparam logic [31:0] USED =
        (W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << W) - 32'd1);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(hash_base(SLOT_SHIFT));
    localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(hash_base(SLOT_SHIFT) + 8*REGS);

    logic [31:0]       ind_q [REGS];
    logic [31:0]       grp_q [REGS];
    logic [ADDR_W-1:0] off;
    logic              in_win;
    logic [IDXW-1:0]   widx;
    logic [RIDXW-1:0]  lk_reg;
    logic [31:0]       lk_mask;

    always_comb begin
        off    = cfg_addr - BASE_A;
        in_win = (cfg_addr >= BASE_A) && (cfg_addr < END_A) && (cfg_addr[1:0] == 2'b00);
        widx   = IDXW'(off >> 2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < REGS; r++) begin
                ind_q[r] <= '0;
                grp_q[r] <= '0;
            end
        end else if (cfg_we && in_win) begin
            if (widx[IDXW-1])
                grp_q[widx[RIDXW-1:0]] <= cfg_wdata & USED;
            else
                ind_q[widx[RIDXW-1:0]] <= cfg_wdata & USED;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (in_win)
            cfg_rdata = widx[IDXW-1] ? grp_q[widx[RIDXW-1:0]] : ind_q[widx[RIDXW-1:0]];
    end

    // Slot lookup: word by upper slot bits, bit MSB-first by lower bits.
    always_comb begin
        lk_reg  = RIDXW'(lk_slot >> WIDTH_SHIFT);
        lk_mask = (32'd1 << (W - 1)) >> lk_slot[WIDTH_SHIFT-1:0];
        lk_hit  = |(grp_q[lk_reg] & lk_mask);
    end
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
    import mhf_pkg::*;
(
    input  req_t req,
    input  logic hash_hit,
    output logic accept
);
    always_comb begin
        if (req.mode.promisc)
            accept = 1'b1;
        else if (req.mc)
            accept = req.mode.allmc | (req.mode.hash_en & hash_hit);
        else
            accept = req.uc_hit;
    end
endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter
    import mhf_pkg::*;
#(
    parameter int SLOT_SHIFT  = 6,
    parameter int WIDTH_SHIFT = 4,
    parameter int ADDR_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              da_valid,
    input  logic [47:0]       da,
    input  logic              uc_match,
    input  logic              mode_promisc,
    input  logic              mode_allmc,
    input  logic              mode_hash_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              dec_valid,
    output logic              dec_accept
);
    logic [SLOT_SHIFT-1:0] slot_c;
    logic [SLOT_SHIFT-1:0] s1_slot;
    req_t                  req_c;
    req_t                  s1_req;
    logic                  s1_vld;
    logic                  hash_hit;
    logic                  acc_c;

    mhf_crc_slot #(.SLOT_SHIFT(SLOT_SHIFT)) u_crc (
        .da   (da),
        .slot (slot_c)
    );

    always_comb begin
        req_c.mc           = da[40];
        req_c.uc_hit       = uc_match;
        req_c.mode.promisc = mode_promisc;
        req_c.mode.allmc   = mode_allmc;
        req_c.mode.hash_en = mode_hash_en;
    end

    // Stage 1: capture slot and request.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld  <= 1'b0;
            s1_req  <= '0;
            s1_slot <= '0;
        end else begin
            s1_vld  <= da_valid;
            s1_req  <= req_c;
            s1_slot <= slot_c;
        end
    end

    mhf_table_bank #(
        .SLOT_SHIFT  (SLOT_SHIFT),
        .WIDTH_SHIFT (WIDTH_SHIFT),
        .ADDR_W      (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .lk_slot   (s1_slot),
        .lk_hit    (hash_hit)
    );

    mhf_decide u_decide (
        .req      (s1_req),
        .hash_hit (hash_hit),
        .accept   (acc_c)
    );

    // Stage 2: registered decision.
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= s1_vld;
            dec_accept <= s1_vld & acc_c;
        end
    end
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
    parameter int W = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        da_valid,
    input logic [47:0] da,
    input logic        uc_match,
    input logic        mode_promisc,
    input logic        mode_allmc,
    input logic        mode_hash_en,
    input logic [31:0] cfg_rdata,
    input logic        dec_valid,
    input logic        dec_accept
);
    localparam logic [31:0] USED =
        (W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << W) - 32'd1);

    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)
            age <= 2'd0;
        else if (age != 2'd2)
            age <= age + 2'd1;
    end

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (dec_valid == $past(da_valid, 2)));

    assert_promisc_R5: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && dec_valid && $past(mode_promisc, 2)) |-> dec_accept);

    assert_allmc_R6: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && dec_valid && $past(mode_allmc, 2) && $past(da[40], 2)) |-> dec_accept);

    assert_unicast_R8: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && dec_valid && !$past(mode_promisc, 2) && !$past(da[40], 2))
        |-> (dec_accept == $past(uc_match, 2)));

    assert_hash_off_R7: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && dec_valid && $past(da[40], 2) && !$past(mode_promisc, 2)
         && !$past(mode_allmc, 2) && !$past(mode_hash_en, 2)) |-> !dec_accept);

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~USED) == 32'd0);

    assert_reset_clear_R4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_rdata == 32'd0 && !dec_valid));
endmodule

bind mc_hash_filter mhf_checker #(.W(1 << WIDTH_SHIFT)) u_mhf_chk (
    .clk          (clk),
    .rst          (rst),
    .da_valid     (da_valid),
    .da           (da),
    .uc_match     (uc_match),
    .mode_promisc (mode_promisc),
    .mode_allmc   (mode_allmc),
    .mode_hash_en (mode_hash_en),
    .cfg_rdata    (cfg_rdata),
    .dec_valid    (dec_valid),
    .dec_accept   (dec_accept)
);

// File: tb/mc_hash_filter_bench.sv
module mc_hash_filter_bench;
    localparam int B_SLOTS = 64;
    localparam int B_W     = 16;
    localparam int B_REGS  = 4;
    localparam logic [7:0] B_BASE = 8'h30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        uc_match = 1'b0;
    logic        mode_promisc = 1'b0;
    logic        mode_allmc = 1'b0;
    logic        mode_hash_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dec_valid;
    logic        dec_accept;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] ref_ind [B_REGS];
    logic [31:0] ref_grp [B_REGS];

    always #4 clk = ~clk;

    mc_hash_filter u_mc_hash_filter (
        .clk(clk), .rst(rst), .da_valid(da_valid), .da(da), .uc_match(uc_match),
        .mode_promisc(mode_promisc), .mode_allmc(mode_allmc), .mode_hash_en(mode_hash_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R1: reference CRC, bit by bit over the 48 address bits.
    function automatic logic [31:0] b_crc(input logic [47:0] a);
        logic [31:0] c;
        logic        bitv;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            bitv = a[40 - 8*(k/8) + (k%8)];
            if (c[31] ^ bitv) c = (c << 1) ^ 32'h04C1_1DB7;
            else              c = c << 1;
        end
        return c;
    endfunction

    function automatic int b_slot(input logic [47:0] a);
        logic [31:0] c;
        c = b_crc(a);
        return (B_SLOTS - 1) - int'(c >> 26);
    endfunction

    // R2: group bit of a slot.
    function automatic bit b_bit(input int s);
        logic [31:0] m;
        m = 32'h8000 >> (s % B_W);
        return (ref_grp[s / B_W] & m) != 0;
    endfunction

    function automatic bit b_acc(input logic [47:0] a, input bit uc, input bit p,
                                 input bit am, input bit h);
        if (p) return 1'b1;
        if (a[40]) return am | (h & b_bit(b_slot(a)));
        return uc;
    endfunction

    function automatic logic [31:0] b_read(input logic [7:0] ad);
        int idx;
        if (ad < B_BASE || ad >= B_BASE + 8*B_REGS || ad[1:0] != 2'b00) return 32'h0;
        idx = int'(ad - B_BASE) / 4;
        return (idx < B_REGS) ? ref_ind[idx] : ref_grp[idx - B_REGS];
    endfunction

    task automatic wr(input logic [7:0] ad, input logic [31:0] d);
        int idx;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ad >= B_BASE && ad < B_BASE + 8*B_REGS && ad[1:0] == 2'b00) begin
            idx = int'(ad - B_BASE) / 4;
            if (idx < B_REGS) ref_ind[idx] = d & 32'h0000_FFFF;
            else              ref_grp[idx - B_REGS] = d & 32'h0000_FFFF;
        end
    endtask

    task automatic rd(input logic [7:0] ad, input string tag);
        @(negedge clk);
        cfg_addr = ad;
        #1;
        chk(tag, cfg_rdata, b_read(ad));
    endtask

    task automatic probe(input logic [47:0] a, input bit uc, input bit p, input bit am,
                         input bit h, input string tag);
        bit e;
        e = b_acc(a, uc, p, am, h);
        @(negedge clk);
        da = a; uc_match = uc; mode_promisc = p; mode_allmc = am; mode_hash_en = h;
        da_valid = 1'b1;
        @(negedge clk);
        da_valid = 1'b0; da = ~a; uc_match = ~uc; mode_promisc = ~p; mode_allmc = ~am;
        mode_hash_en = ~h;
        chk({tag, " R9 early"}, {31'd0, dec_valid}, 32'd0);
        @(negedge clk);
        chk({tag, " R9 valid"}, {31'd0, dec_valid}, 32'd1);
        chk(tag, {31'd0, dec_accept}, {31'd0, e});
    endtask

    task automatic set_grp_slot(input int s, input bit invert);
        for (int r = 0; r < B_REGS; r++) begin
            logic [31:0] v;
            v = (r == s / B_W) ? (32'h8000 >> (s % B_W)) : 32'h0;
            if (invert) v = ~v;
            wr(B_BASE + 8'(16 + 4*r), v);
        end
    endtask

    initial begin
        for (int r = 0; r < B_REGS; r++) begin
            ref_ind[r] = '0;
            ref_grp[r] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R4: reset state
        chk("R4 dec_valid", {31'd0, dec_valid}, 32'd0);
        for (int r = 0; r < 2*B_REGS; r++) rd(B_BASE + 8'(4*r), "R4 reset word");

        // R10: unused upper bits
        wr(B_BASE + 8'd16, 32'hFFFF_FFFF);
        rd(B_BASE + 8'd16, "R10 upper bits");
        wr(B_BASE + 8'd4, 32'hA5A5_1234);
        rd(B_BASE + 8'd4, "R3 individual word");

        // R3: out-of-window and unaligned accesses
        wr(B_BASE - 8'd4, 32'hDEAD_BEEF);
        wr(B_BASE + 8'd32, 32'hDEAD_BEEF);
        wr(B_BASE + 8'd5, 32'hDEAD_BEEF);
        rd(B_BASE - 8'd4, "R3 below window");
        rd(B_BASE + 8'd32, "R3 above window");
        rd(B_BASE + 8'd5, "R3 unaligned");
        for (int r = 0; r < 2*B_REGS; r++) rd(B_BASE + 8'(4*r), "R3 unchanged");

        // R11 / R8: unicast with full group table is not hashed
        for (int r = 0; r < B_REGS; r++) wr(B_BASE + 8'(16 + 4*r), 32'hFFFF);
        probe(48'hFEFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, "R8 R11 unicast reject");
        probe(48'h0200_0000_0001, 1'b1, 1'b0, 1'b0, 1'b1, "R8 unicast match");
        probe(48'h0100_5E00_0001, 1'b0, 1'b0, 1'b0, 1'b1, "R11 multicast hashed");

        // R1 / R2: single slot set, then all but that slot
        begin
            logic [47:0] m;
            int s;
            m = 48'h0100_5E7F_0A0B;
            s = b_slot(m);
            set_grp_slot(s, 1'b0);
            probe(m, 1'b0, 1'b0, 1'b0, 1'b1, "R1 R2 lone slot");
            probe(m, 1'b0, 1'b0, 1'b0, 1'b0, "R7 hash disabled");
            set_grp_slot(s, 1'b1);
            probe(m, 1'b0, 1'b0, 1'b0, 1'b1, "R2 complement");
            probe(m, 1'b0, 1'b0, 1'b1, 1'b1, "R6 allmc");
            probe(48'h3300_0000_0001, 1'b0, 1'b1, 1'b0, 1'b0, "R5 promisc");
            probe(48'h0000_0000_0001, 1'b0, 1'b0, 1'b1, 1'b1, "R6 allmc unicast");
        end

        // Random mix
        void'($urandom(32'd20240611));
        for (int n = 0; n < 400; n++) begin
            logic [47:0] a;
            bit p, am, h, uc;
            string tag;
            if (n % 25 == 0) begin
                for (int r = 0; r < B_REGS; r++) wr(B_BASE + 8'(16 + 4*r), $urandom);
                wr(B_BASE + 8'(4 * ($urandom % B_REGS)), $urandom);
                rd(B_BASE + 8'(4 * ($urandom % (2*B_REGS))), "R3 R10 random read");
            end
            a  = {16'($urandom), $urandom};
            p  = ($urandom % 8) == 0;
            am = ($urandom % 8) == 0;
            h  = ($urandom % 4) != 0;
            uc = $urandom % 2;
            if (p)          tag = "R5 random";
            else if (!a[40]) tag = "R8 random";
            else if (am)    tag = "R6 random";
            else            tag = "R1 R7 random";
            probe(a, uc, p, am, h, tag);
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule